// File: doc/BRIEF.md
# UART FIFO DMA Request Generator

This block sits beside the receive and transmit FIFOs of a UART and decides when a DMA controller should be asked to move data. On the receive side it compares the FIFO fill level against a threshold chosen by a two-bit code. It raises a receive request when the level reaches that threshold or when a character time-out strobe arrives. On the transmit side it raises a request on the one cycle in which the FIFO stops being full.

Each request is held until the DMA controller returns a clear strobe. Both requests are allowed only while FIFO operation and DMA mode are switched on together. The receive threshold comparison is also brought out as an interrupt condition. That condition needs FIFO operation but not DMA mode.

Top module: `uart_dmareq_gen`

## Requirements
- R1: Neither request may be high in the cycle after one in which `fifo_on` and `dma_sel` are not both 1. While that is so, the held request is discarded.
- R2: While DMA is active, a receive level at or above the decoded threshold makes `rx_dreq` high in the following cycle.
- R3: While DMA is active, a high `rx_tmo` makes `rx_dreq` high in the following cycle, even when the level is below the threshold.
- R4: The trigger code decodes as 0 → 1, 1 → 4, 2 → 8 and 3 → 14 characters.
- R5: `tx_dreq` is set only by a cycle in which `tx_full` is 0 and was 1 in the previous cycle. A FIFO that stays not full sets nothing.
- R6: A request stays high until its clear strobe (`rx_dreq_clr` or `tx_dreq_clr`) is seen. It then drops in the next cycle unless a set condition is present in the same cycle.
- R7: When a set condition and the matching clear strobe fall in the same cycle, the request is high in the next cycle.
- R8: After synchronous reset both requests are 0, and the previous-full history is 0, so deasserting `tx_full` right after reset sets nothing.
- R9: `rx_lvl_irq` equals `fifo_on` AND (level ≥ decoded threshold) combinationally, regardless of `dma_sel`. A level of 0 never raises it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_on | input | 1 | FIFO operation enable |
| dma_sel | input | 1 | DMA mode select, effective only with `fifo_on` |
| trig_code | input | 2 | Receive threshold code |
| rx_fill | input | LEVEL_W (5) | Receive FIFO fill level |
| rx_tmo | input | 1 | Character time-out strobe |
| tx_full | input | 1 | Transmit FIFO full flag |
| rx_dreq_clr | input | 1 | Receive request clear from the DMA controller |
| tx_dreq_clr | input | 1 | Transmit request clear from the DMA controller |
| rx_dreq | output | 1 | Receive DMA request |
| tx_dreq | output | 1 | Transmit DMA request |
| rx_lvl_irq | output | 1 | Receive threshold interrupt condition |

## Verification
The clash that matters is a set condition and a clear strobe arriving in the same cycle. On the receive side the set comes from a level or a time-out, and on the transmit side from the full-to-not-full edge. The bench provokes it by asserting the clear while it drives a level at threshold, while it pulses `rx_tmo`, and while it drops `tx_full`. It judges the result by requiring the request to be high in the next cycle. A separate cycle with the clear alone must then show the request low.

// File: rtl/uart_dmareq_pkg.sv
package uart_dmareq_pkg;

    localparam int LVL_W_DEF = 5;
    localparam int DEPTH_W   = 8;

    typedef enum logic [1:0] {
        TRIG_ONE     = 2'd0,
        TRIG_FOUR    = 2'd1,
        TRIG_EIGHT   = 2'd2,
        TRIG_FOURTEEN = 2'd3
    } trig_code_e;

    typedef struct packed {
        logic       fifo_on;
        logic       dma_sel;
        trig_code_e trig;
    } dreq_ctrl_t;

    typedef struct packed {
        logic set;
        logic clr;
    } dreq_ev_t;

    function automatic logic [DEPTH_W-1:0] trig_depth(input trig_code_e c);
        case (c)
            TRIG_ONE:   trig_depth = 8'd1;
            TRIG_FOUR:  trig_depth = 8'd4;
            TRIG_EIGHT: trig_depth = 8'd8;
            default:    trig_depth = 8'd14;
        endcase
    endfunction

    function automatic logic dma_active(input dreq_ctrl_t c);
        dma_active = c.fifo_on & c.dma_sel;
    endfunction

endpackage

// File: rtl/uart_dmareq_thresh.sv
module uart_dmareq_thresh
    import uart_dmareq_pkg::*;
#(
    parameter int LEVEL_W = LVL_W_DEF
) (
    input  trig_code_e           trig,
    input  logic [LEVEL_W-1:0]   level,
    output logic                 at_thresh
);
    localparam int CMP_W = (LEVEL_W > DEPTH_W) ? LEVEL_W : DEPTH_W;

    logic [CMP_W-1:0] lvl_ext;
    logic [CMP_W-1:0] thr_ext;

    always_comb begin
        lvl_ext   = CMP_W'(level);
        thr_ext   = CMP_W'(trig_depth(trig));
        at_thresh = (lvl_ext >= thr_ext);
    end
endmodule

// File: rtl/uart_dmareq_edge.sv
module uart_dmareq_edge (
    input  logic clk,
    input  logic rst,
    input  logic full,
    output logic left_full
);
    logic full_q;

    always_ff @(posedge clk) begin
        if (rst) full_q <= 1'b0;
        else     full_q <= full;
    end

    assign left_full = full_q & ~full;
endmodule

// File: rtl/uart_dmareq_cell.sv
module uart_dmareq_cell
    import uart_dmareq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     allow,
    input  dreq_ev_t ev,
    output logic     req
);
    logic req_q;

    always_ff @(posedge clk) begin
        if (rst)          req_q <= 1'b0;
        else if (!allow)  req_q <= 1'b0;
        else if (ev.set)  req_q <= 1'b1;
        else if (ev.clr)  req_q <= 1'b0;
    end

    assign req = req_q;
endmodule

// File: rtl/uart_dmareq_gen.sv
module uart_dmareq_gen
    import uart_dmareq_pkg::*;
#(
    parameter int LEVEL_W = LVL_W_DEF
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               fifo_on,
    input  logic               dma_sel,
    input  logic [1:0]         trig_code,
    input  logic [LEVEL_W-1:0] rx_fill,
    input  logic               rx_tmo,
    input  logic               tx_full,
    input  logic               rx_dreq_clr,
    input  logic               tx_dreq_clr,
    output logic               rx_dreq,
    output logic               tx_dreq,
    output logic               rx_lvl_irq
);
    localparam int NREQ = 2;

    dreq_ctrl_t ctrl;
    logic       active;
    logic       at_thr;
    logic       tx_left_full;
    dreq_ev_t   ev   [NREQ];
    logic       reqs [NREQ];

    always_comb begin
        ctrl.fifo_on = fifo_on;
        ctrl.dma_sel = dma_sel;
        ctrl.trig    = trig_code_e'(trig_code);
        active       = dma_active(ctrl);
    end

    uart_dmareq_thresh #(.LEVEL_W(LEVEL_W)) u_thr (
        .trig      (ctrl.trig),
        .level     (rx_fill),
        .at_thresh (at_thr)
    );

    uart_dmareq_edge u_edge (
        .clk       (clk),
        .rst       (rst),
        .full      (tx_full),
        .left_full (tx_left_full)
    );

    always_comb begin
        ev[0].set = at_thr | rx_tmo;
        ev[0].clr = rx_dreq_clr;
        ev[1].set = tx_left_full;
        ev[1].clr = tx_dreq_clr;
    end

    for (genvar g = 0; g < NREQ; g++) begin : g_req
        uart_dmareq_cell u_cell (
            .clk   (clk),
            .rst   (rst),
            .allow (active),
            .ev    (ev[g]),
            .req   (reqs[g])
        );
    end

    assign rx_dreq    = reqs[0];
    assign tx_dreq    = reqs[1];
    assign rx_lvl_irq = fifo_on & at_thr;
endmodule

// File: rtl/uart_dmareq_chk.sv
module uart_dmareq_chk #(
    parameter int LEVEL_W = 5
) (
    input logic               clk,
    input logic               rst,
    input logic               fifo_on,
    input logic               dma_sel,
    input logic [LEVEL_W-1:0] rx_fill,
    input logic               rx_tmo,
    input logic               tx_full,
    input logic               rx_dreq_clr,
    input logic               tx_dreq_clr,
    input logic               rx_dreq,
    input logic               tx_dreq,
    input logic               rx_lvl_irq
);
    logic act;
    logic prev_full;

    assign act = fifo_on & dma_sel;

    always_ff @(posedge clk) begin
        if (rst) prev_full <= 1'b0;
        else     prev_full <= tx_full;
    end

    AST_RX_GATED: assert property (@(posedge clk) disable iff (rst)
        !act |=> !rx_dreq);                                        // R1
    AST_TX_GATED: assert property (@(posedge clk) disable iff (rst)
        !act |=> !tx_dreq);                                        // R1
    AST_RX_LEVEL_SET: assert property (@(posedge clk) disable iff (rst)
        (act && rx_lvl_irq) |=> rx_dreq);                          // R2
    AST_RX_TMO_SET: assert property (@(posedge clk) disable iff (rst)
        (act && rx_tmo) |=> rx_dreq);                              // R3
    AST_TX_EDGE_SET: assert property (@(posedge clk) disable iff (rst)
        (act && prev_full && !tx_full) |=> tx_dreq);               // R5
    AST_TX_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
        (!tx_dreq && !(prev_full && !tx_full)) |=> !tx_dreq);      // R5
    AST_TX_HOLD: assert property (@(posedge clk) disable iff (rst)
        (act && tx_dreq && !tx_dreq_clr) |=> tx_dreq);             // R6
    AST_RX_HOLD: assert property (@(posedge clk) disable iff (rst)
        (act && rx_dreq && !rx_dreq_clr) |=> rx_dreq);             // R6
    AST_IRQ_ZERO_LEVEL: assert property (@(posedge clk) disable iff (rst)
        (rx_fill == '0) |-> !rx_lvl_irq);                          // R9
    AST_IRQ_NEEDS_FIFO: assert property (@(posedge clk) disable iff (rst)
        !fifo_on |-> !rx_lvl_irq);                                 // R9
endmodule

bind uart_dmareq_gen uart_dmareq_chk #(.LEVEL_W(LEVEL_W)) u_chk (.*);

// File: tb/sim_uart_dmareq_gen.sv
`timescale 1ns/1ps
module sim_uart_dmareq_gen;
    logic       clk = 1'b0;
    logic       rst;
    logic       fifo_on, dma_sel, rx_tmo, tx_full, rx_dreq_clr, tx_dreq_clr;
    logic [1:0] trig_code;
    logic [4:0] rx_fill;
    logic       rx_dreq, tx_dreq, rx_lvl_irq;

    int n_chk = 0;
    int n_err = 0;

    always #4 clk = ~clk;

    uart_dmareq_gen u0 (
        .clk(clk), .rst(rst), .fifo_on(fifo_on), .dma_sel(dma_sel),
        .trig_code(trig_code), .rx_fill(rx_fill), .rx_tmo(rx_tmo),
        .tx_full(tx_full), .rx_dreq_clr(rx_dreq_clr), .tx_dreq_clr(tx_dreq_clr),
        .rx_dreq(rx_dreq), .tx_dreq(tx_dreq), .rx_lvl_irq(rx_lvl_irq)
    );

    task automatic check(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: got %0b expected %0b", req, act, exp);
        end
    endtask

    // Inputs change just after the sample point, one cycle advances here.
    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    function automatic int exp_thr(input int code);
        if (code == 0) return 1;
        if (code == 3) return 14;
        return 4 * code;
    endfunction

    task automatic idle_inputs();
        rx_fill = '0; rx_tmo = 0; rx_dreq_clr = 0; tx_dreq_clr = 0;
    endtask

    task automatic flush();
        idle_inputs();
        rx_dreq_clr = 1; tx_dreq_clr = 1;
        tick();
        rx_dreq_clr = 0; tx_dreq_clr = 0;
    endtask

    initial begin
        #1_600_000;
        n_err++;
        $display("FAIL watchdog: got hung expected done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        rst = 1; fifo_on = 0; dma_sel = 0; trig_code = 0; tx_full = 0;
        idle_inputs();
        tick(); tick();
        check("R8 rx reset", rx_dreq, 1'b0);
        check("R8 tx reset", tx_dreq, 1'b0);
        rst = 0;
        fifo_on = 1; dma_sel = 1;
        tick();
        check("R8 no tx edge after reset", tx_dreq, 1'b0);

        // R2 R4 R9: sweep every code and level
        for (int c = 0; c < 4; c++) begin
            for (int l = 0; l <= 16; l++) begin
                trig_code = 2'(c);
                flush();
                check("R6 clear drops rx", rx_dreq, 1'b0);
                rx_fill = 5'(l);
                #1;
                check("R4 R9 irq threshold", rx_lvl_irq, l >= exp_thr(c));
                tick();
                check("R2 level set", rx_dreq, l >= exp_thr(c));
                rx_fill = 0;
                tick();
                check("R6 rx held", rx_dreq, l >= exp_thr(c));
            end
        end

        // R9: irq independent of dma_sel, needs fifo_on
        trig_code = 2'd1; rx_fill = 5'd4; dma_sel = 0; #1;
        check("R9 irq without dma", rx_lvl_irq, 1'b1);
        tick();
        check("R1 no rx req without dma", rx_dreq, 1'b0);
        fifo_on = 0; #1;
        check("R9 irq off without fifo", rx_lvl_irq, 1'b0);
        dma_sel = 1; rx_tmo = 1;
        tick();
        check("R1 dma_sel ignored without fifo_on", rx_dreq, 1'b0);
        fifo_on = 1; dma_sel = 1;
        flush();

        // R3: time-out below threshold
        trig_code = 2'd3; rx_fill = 5'd2; rx_tmo = 1;
        tick();
        check("R3 timeout set", rx_dreq, 1'b1);
        rx_tmo = 0;
        tick();
        check("R6 timeout req held", rx_dreq, 1'b1);
        // R7: timeout with clear
        rx_tmo = 1; rx_dreq_clr = 1;
        tick();
        check("R7 rx tmo wins over clear", rx_dreq, 1'b1);
        rx_tmo = 0;
        tick();
        check("R6 rx clear alone", rx_dreq, 1'b0);
        // R7: level with clear
        rx_fill = 5'd14;
        tick();
        check("R7 rx level wins over clear", rx_dreq, 1'b1);
        flush();

        // R1: held request discarded when DMA turns off
        rx_tmo = 1; tick(); rx_tmo = 0;
        dma_sel = 0; tick();
        check("R1 held rx discarded", rx_dreq, 1'b0);
        dma_sel = 1; tick();
        check("R1 rx stays low after re-enable", rx_dreq, 1'b0);

        // R5: tx edge
        tx_full = 0; tick(); tick();
        check("R5 steady not full", tx_dreq, 1'b0);
        tx_full = 1; tick();
        check("R5 going full", tx_dreq, 1'b0);
        tx_full = 0; tick();
        check("R5 full to not full", tx_dreq, 1'b1);
        tick();
        check("R6 tx held", tx_dreq, 1'b1);
        tx_dreq_clr = 1; tick(); tx_dreq_clr = 0;
        check("R6 tx cleared", tx_dreq, 1'b0);
        tick(); tick();
        check("R5 no reset while not full", tx_dreq, 1'b0);
        tx_full = 1; tick();
        tx_full = 0; tx_dreq_clr = 1; tick(); tx_dreq_clr = 0;
        check("R7 tx edge wins over clear", tx_dreq, 1'b1);
        tx_dreq_clr = 1; tick(); tx_dreq_clr = 0;
        check("R6 tx clear alone", tx_dreq, 1'b0);
        tx_full = 1; tick();
        fifo_on = 0; tx_full = 0; tick();
        check("R1 tx edge ignored without fifo_on", tx_dreq, 1'b0);
        fifo_on = 1; tick();
        check("R1 tx edge not replayed", tx_dreq, 1'b0);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule